// File: doc/BRIEF.md
# Snooping MESI Line-State Controller

This block keeps a small private cache coherent on a shared snooping bus. It holds a direct-mapped tag and state store. Every line is in one of four states: Modified (sole copy, dirty), Exclusive (sole cached copy, clean), Shared (a clean copy that other caches may also hold) or Invalid. The block takes one processor read or write at a time and decides whether the request needs bus traffic. When it does, it raises a bus request (read, read-exclusive or writeback) and waits for the grant. At the grant it samples the wired-OR shared line, which lets a read fill land in Exclusive when no other cache holds the line. A later write to that line then upgrades to Modified without any bus traffic.

The block also watches every transaction that other agents place on the bus. Within the same cycle it reports whether it holds a copy (the shared line) and whether it holds dirty data that it must supply (the flush line). At the next clock edge it downgrades or invalidates its own copy. The caller holds a processor request steady until `cpu_done` pulses. The bus arbiter never grants this block in a cycle in which it presents a snooped transaction to it.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_done` and `bus_req_valid` are low. Snoops issued before any fill assert neither `snp_shared` nor `snp_flush`.
- R2: A processor read that misses raises a bus request with command code 2'b01 (read) and the requested address. At the grant the line fills Exclusive if `bus_shared_in` is low and Shared if it is high.
- R3: A processor write that misses, or that hits a Shared line, raises command code 2'b10 (read-exclusive) with the requested address. At the grant the line becomes Modified.
- R4: A processor write that hits an Exclusive or Modified line leaves the line Modified and raises no bus request. `cpu_done` pulses one cycle after the request is presented.
- R5: A processor read that hits a valid line raises no bus request, and `cpu_done` pulses one cycle after the request. After a bus transaction, `cpu_done` pulses one cycle after the last grant. `cpu_done` is always a single-cycle pulse.
- R6: `snp_shared` is high in the same cycle as a snooped read (code 2'b01) whose address matches a valid line. A snooped writeback (code 2'b11) changes nothing and asserts neither output.
- R7: On a snooped read, a Modified line asserts `snp_flush` in that cycle. A Modified or Exclusive line becomes Shared, and a Shared line stays Shared.
- R8: On a snooped read-exclusive (code 2'b10), any valid matching line becomes Invalid. A Modified line also asserts `snp_flush` in that cycle.
- R9: A snoop that arrives in the same cycle as a new processor request to the same line index is applied first. The request is then evaluated against the state the snoop leaves behind.
- R10: A miss whose victim line is Modified first raises a writeback (code 2'b11) carrying the victim's address. The fill request follows only after that writeback is granted. An Exclusive or Shared victim is dropped without bus traffic.
- R11: With two controllers on one bus, no line address is ever held Modified or Exclusive in one cache while it is valid in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present; held until `cpu_done` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Line address (tag above index) |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 1 read, 2 read-exclusive, 3 writeback |
| bus_req_addr | output | ADDR_W | Address of the requested transaction |
| bus_gnt | input | 1 | Arbiter grant; the transaction takes place in this cycle |
| bus_shared_in | input | 1 | Wired-OR shared line from the other caches |
| snp_valid | input | 1 | Another agent's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped read's line |
| snp_flush | output | 1 | This cache must supply its dirty data |

## Verification
The snoop outputs respond in the same cycle as the snooped transaction. The bench therefore drives a snoop away from the clock edge and samples `snp_shared` and `snp_flush` 1 ns later. The state change that a snoop causes appears one edge later, so it is checked through the next transaction's bus commands and snoop responses. A hit must complete exactly one cycle after the request is presented. A transaction that uses the bus must complete exactly one cycle after its last grant. The bench counts negative edges from the request and compares the count against these two numbers. It also compares every bus command and address, in order, against a reference list built from its model of both caches.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

   typedef enum logic [1:0] {
      LS_I = 2'd0,
      LS_S = 2'd1,
      LS_E = 2'd2,
      LS_M = 2'd3
   } line_state_t;

   typedef enum logic [1:0] {
      BC_NONE = 2'd0,
      BC_RD   = 2'd1,
      BC_RDX  = 2'd2,
      BC_WB   = 2'd3
   } bus_cmd_t;

   typedef enum logic [1:0] {
      CS_IDLE  = 2'd0,
      CS_EVICT = 2'd1,
      CS_FETCH = 2'd2,
      CS_DONE  = 2'd3
   } ctl_state_t;

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
   import mesi_pkg::*;
#(
   parameter int INDEX_W = 2,
   parameter int TAG_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INDEX_W-1:0] a_idx,
   output logic [TAG_W-1:0]   a_tag,
   output line_state_t        a_state,
   input  logic [INDEX_W-1:0] b_idx,
   output logic [TAG_W-1:0]   b_tag,
   output line_state_t        b_state,
   input  logic               c_we,
   input  logic [TAG_W-1:0]   c_tag,
   input  line_state_t        c_state,
   input  logic               s_we,
   input  line_state_t        s_state
);
   localparam int LINES = 1 << INDEX_W;

   line_state_t      st_q  [LINES];
   logic [TAG_W-1:0] tag_q [LINES];

   // processor port writes first, snoop port last so it wins on a shared index
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) begin
            st_q[i]  <= LS_I;
            tag_q[i] <= '0;
         end
      end else begin
         if (c_we) begin
            tag_q[a_idx] <= c_tag;
            st_q[a_idx]  <= c_state;
         end
         if (s_we) begin
            st_q[b_idx] <= s_state;
         end
      end
   end

   assign a_tag   = tag_q[a_idx];
   assign a_state = st_q[a_idx];
   assign b_tag   = tag_q[b_idx];
   assign b_state = st_q[b_idx];

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
   import mesi_pkg::*;
#(
   parameter int TAG_W = 6
) (
   input  logic             snp_valid,
   input  bus_cmd_t         snp_cmd,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic [TAG_W-1:0] line_tag,
   input  line_state_t      line_state,
   output logic             shared,
   output logic             flush,
   output logic             upd_en,
   output line_state_t      upd_state
);
   logic hit;

   always_comb begin
      hit       = snp_valid && (line_state != LS_I) && (line_tag == snp_tag);
      shared    = hit && (snp_cmd == BC_RD);
      flush     = hit && (line_state == LS_M) &&
                  ((snp_cmd == BC_RD) || (snp_cmd == BC_RDX));
      upd_en    = 1'b0;
      upd_state = line_state;
      if (hit && snp_cmd == BC_RDX) begin
         upd_en    = 1'b1;
         upd_state = LS_I;
      end else if (hit && snp_cmd == BC_RD && line_state != LS_S) begin
         upd_en    = 1'b1;
         upd_state = LS_S;
      end
   end

endmodule

// File: rtl/mesi_cpu_fsm.sv
module mesi_cpu_fsm
   import mesi_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int INDEX_W = 2,
   parameter int TAG_W   = ADDR_W - INDEX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [TAG_W-1:0]  line_tag,
   input  line_state_t       line_state,
   input  logic              snoop_block,
   input  logic              bus_gnt,
   input  logic              bus_shared_in,
   output logic              done,
   output logic              bus_req_valid,
   output bus_cmd_t          bus_req_cmd,
   output logic [ADDR_W-1:0] bus_req_addr,
   output logic              wr_en,
   output logic [TAG_W-1:0]  wr_tag,
   output line_state_t       wr_state
);
   ctl_state_t cur_q, nxt;
   bus_cmd_t   fetch_q, fetch_d;
   logic       hit, owns;
   logic [TAG_W-1:0] req_tag;

   assign req_tag = req_addr[ADDR_W-1:INDEX_W];
   assign hit     = (line_state != LS_I) && (line_tag == req_tag);
   assign owns    = (line_state == LS_M) || (line_state == LS_E);

   always_comb begin
      nxt           = cur_q;
      fetch_d       = fetch_q;
      done          = (cur_q == CS_DONE);
      bus_req_valid = 1'b0;
      bus_req_cmd   = BC_NONE;
      bus_req_addr  = req_addr;
      wr_en         = 1'b0;
      wr_tag        = line_tag;
      wr_state      = line_state;
      case (cur_q)
         CS_IDLE: begin
            if (req_valid && !snoop_block) begin
               if (hit && (!req_write || owns)) begin
                  nxt = CS_DONE;
                  if (req_write && line_state == LS_E) begin
                     wr_en    = 1'b1;
                     wr_state = LS_M;
                  end
               end else begin
                  fetch_d = req_write ? BC_RDX : BC_RD;
                  nxt     = (!hit && line_state == LS_M) ? CS_EVICT : CS_FETCH;
               end
            end
         end
         CS_EVICT: begin
            if (line_state != LS_M) begin
               nxt = CS_FETCH;
            end else begin
               bus_req_valid = 1'b1;
               bus_req_cmd   = BC_WB;
               bus_req_addr  = {line_tag, req_addr[INDEX_W-1:0]};
               if (bus_gnt) begin
                  wr_en    = 1'b1;
                  wr_state = LS_I;
                  nxt      = CS_FETCH;
               end
            end
         end
         CS_FETCH: begin
            bus_req_valid = 1'b1;
            bus_req_cmd   = fetch_q;
            if (bus_gnt) begin
               wr_en    = 1'b1;
               wr_tag   = req_tag;
               wr_state = (fetch_q == BC_RDX) ? LS_M :
                          (bus_shared_in ? LS_S : LS_E);
               nxt      = CS_DONE;
            end
         end
         default: nxt = CS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q   <= CS_IDLE;
         fetch_q <= BC_RD;
      end else begin
         cur_q   <= nxt;
         fetch_q <= fetch_d;
      end
   end

   // R2
   fill_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == CS_FETCH && bus_gnt && fetch_q == BC_RD)
      |=> !$stable(req_addr) || line_state == ($past(bus_shared_in) ? LS_S : LS_E));

   // R3
   rdx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == CS_FETCH && bus_gnt && fetch_q == BC_RDX)
      |=> !$stable(req_addr) || line_state == LS_M);

   // R4
   silent_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == CS_IDLE && req_valid && req_write && !snoop_block && hit && line_state == LS_E)
      |=> done && !bus_req_valid);

   // R5
   read_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == CS_IDLE && req_valid && !req_write && !snoop_block && hit)
      |=> done && !bus_req_valid);

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == CS_IDLE && req_valid && snoop_block) |=> !done && !bus_req_valid);

   // R10
   evict_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q == CS_IDLE && req_valid && !snoop_block && !hit && line_state == LS_M)
      |=> bus_req_valid && bus_req_cmd == BC_WB);

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int INDEX_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_valid,
   input  logic              cpu_req_write,
   input  logic [ADDR_W-1:0] cpu_req_addr,
   output logic              cpu_done,
   output logic              bus_req_valid,
   output logic [1:0]        bus_req_cmd,
   output logic [ADDR_W-1:0] bus_req_addr,
   input  logic              bus_gnt,
   input  logic              bus_shared_in,
   input  logic              snp_valid,
   input  logic [1:0]        snp_cmd,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_shared,
   output logic              snp_flush
);
   localparam int TAG_W = ADDR_W - INDEX_W;

   generate
      if (INDEX_W < 1 || INDEX_W > 10) begin : g_bad_index
         $error("mesi_line_ctrl: INDEX_W out of range");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("mesi_line_ctrl: ADDR_W must exceed INDEX_W");
      end
   endgenerate

   logic [INDEX_W-1:0] cpu_idx, snp_idx;
   logic [TAG_W-1:0]   snp_tag;
   logic [TAG_W-1:0]   cpu_line_tag, snp_line_tag, wr_tag;
   line_state_t        cpu_line_st, snp_line_st, wr_state, upd_state;
   logic               wr_en, upd_en, snoop_block;
   bus_cmd_t           fsm_cmd, snp_cmd_e;

   assign cpu_idx     = cpu_req_addr[INDEX_W-1:0];
   assign snp_idx     = snp_addr[INDEX_W-1:0];
   assign snp_tag     = snp_addr[ADDR_W-1:INDEX_W];
   assign snp_cmd_e   = bus_cmd_t'(snp_cmd);
   assign snoop_block = snp_valid && (snp_idx == cpu_idx);
   assign bus_req_cmd = fsm_cmd;

   mesi_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) i_store (
      .clk(clk), .rst_n(rst_n),
      .a_idx(cpu_idx), .a_tag(cpu_line_tag), .a_state(cpu_line_st),
      .b_idx(snp_idx), .b_tag(snp_line_tag), .b_state(snp_line_st),
      .c_we(wr_en), .c_tag(wr_tag), .c_state(wr_state),
      .s_we(upd_en), .s_state(upd_state)
   );

   mesi_snoop_unit #(.TAG_W(TAG_W)) i_snoop (
      .snp_valid(snp_valid), .snp_cmd(snp_cmd_e), .snp_tag(snp_tag),
      .line_tag(snp_line_tag), .line_state(snp_line_st),
      .shared(snp_shared), .flush(snp_flush),
      .upd_en(upd_en), .upd_state(upd_state)
   );

   mesi_cpu_fsm #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .TAG_W(TAG_W)) i_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(cpu_req_valid), .req_write(cpu_req_write), .req_addr(cpu_req_addr),
      .line_tag(cpu_line_tag), .line_state(cpu_line_st),
      .snoop_block(snoop_block), .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
      .done(cpu_done), .bus_req_valid(bus_req_valid), .bus_req_cmd(fsm_cmd),
      .bus_req_addr(bus_req_addr),
      .wr_en(wr_en), .wr_tag(wr_tag), .wr_state(wr_state)
   );

   // R7
   snp_rd_downgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd_e == BC_RD && snp_line_st != LS_I && snp_line_tag == snp_tag)
      |=> !$stable(snp_addr) || snp_line_st == LS_S);

   // R8
   snp_rdx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_cmd_e == BC_RDX && snp_line_st != LS_I && snp_line_tag == snp_tag)
      |=> !$stable(snp_addr) || snp_line_st == LS_I);

endmodule

// File: tb/test_mesi_line_ctrl.sv
`timescale 1ns/1ps
module test_mesi_line_ctrl;
   localparam int AW = 8;
   localparam int IW = 2;
   localparam int TW = AW - IW;
   localparam int NC = 2;
   localparam logic [1:0] MI = 2'd0, MS = 2'd1, ME = 2'd2, MM = 2'd3;
   localparam logic [1:0] B_RD = 2'd1, B_RDX = 2'd2, B_WB = 2'd3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NC-1:0] req_valid, req_write, done, bq_valid, gnt, sh_in, s_valid, s_shared, s_flush;
   logic [AW-1:0] req_addr [NC];
   logic [1:0]    bq_cmd   [NC];
   logic [AW-1:0] bq_addr  [NC];
   logic [1:0]    s_cmd    [NC];
   logic [AW-1:0] s_addr   [NC];

   logic [1:0]    mst [NC][4];
   logic [TW-1:0] mtg [NC][4];

   int nvec = 0;
   int nfail = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   generate
      for (genvar g = 0; g < NC; g++) begin : g_cache
         mesi_line_ctrl #(.ADDR_W(AW), .INDEX_W(IW)) i_mesi_line_ctrl (
            .clk(clk), .rst_n(rst_n),
            .cpu_req_valid(req_valid[g]), .cpu_req_write(req_write[g]),
            .cpu_req_addr(req_addr[g]), .cpu_done(done[g]),
            .bus_req_valid(bq_valid[g]), .bus_req_cmd(bq_cmd[g]), .bus_req_addr(bq_addr[g]),
            .bus_gnt(gnt[g]), .bus_shared_in(sh_in[g]),
            .snp_valid(s_valid[g]), .snp_cmd(s_cmd[g]), .snp_addr(s_addr[g]),
            .snp_shared(s_shared[g]), .snp_flush(s_flush[g])
         );
      end
   endgenerate

   assign sh_in[0] = s_shared[1];
   assign sh_in[1] = s_shared[0];

   task automatic check(bit ok, string rq, string what, int act, int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic bit m_hit(int k, logic [AW-1:0] a);
      return mst[k][a[IW-1:0]] != MI && mtg[k][a[IW-1:0]] == a[AW-1:IW];
   endfunction

   function automatic bit exp_shared(int k, logic [1:0] c, logic [AW-1:0] a);
      return c == B_RD && m_hit(k, a);
   endfunction

   function automatic bit exp_flush(int k, logic [1:0] c, logic [AW-1:0] a);
      return (c == B_RD || c == B_RDX) && m_hit(k, a) && mst[k][a[IW-1:0]] == MM;
   endfunction

   // called 1 ns after the snoop is driven: compare, then advance the model
   task automatic snoop_chk_update(int j, logic [1:0] c, logic [AW-1:0] a, string rq);
      bit es, ef;
      es = exp_shared(j, c, a);
      ef = exp_flush(j, c, a);
      check(s_shared[j] == es, rq, "snp_shared", int'(s_shared[j]), int'(es));
      check(s_flush[j] == ef, rq, "snp_flush", int'(s_flush[j]), int'(ef));
      if (m_hit(j, a)) begin
         if (c == B_RDX) mst[j][a[IW-1:0]] = MI;
         else if (c == B_RD) mst[j][a[IW-1:0]] = MS;
      end
   endtask

   // R11: single-owner invariant over the model that tracks both caches
   task automatic inv_chk();
      bit ok = 1'b1;
      for (int i = 0; i < 4; i++) begin
         if (mst[0][i] != MI && mst[1][i] != MI && mtg[0][i] == mtg[1][i] &&
             (mst[0][i] >= ME || mst[1][i] >= ME)) ok = 1'b0;
      end
      check(ok, "R11", "single owner", int'(ok), 1);
   endtask

   task automatic ext_snoop(logic [1:0] c, logic [AW-1:0] a, string rq);
      for (int j = 0; j < NC; j++) begin
         s_valid[j] = 1'b1; s_cmd[j] = c; s_addr[j] = a;
      end
      #1;
      for (int j = 0; j < NC; j++) snoop_chk_update(j, c, a, rq);
      @(negedge clk);
      s_valid = '0;
      inv_chk();
   endtask

   task automatic cpu_op(int k, bit wr, logic [AW-1:0] a, bit with_snp, logic [1:0] sc, string rq);
      logic [1:0]    ec [2];
      logic [AW-1:0] ea [2];
      logic [1:0]    c;
      logic [AW-1:0] ad;
      logic [IW-1:0] idx;
      int n = 0, gi = 0, cyc = 0, last_g = 0, j;
      bit fin = 1'b0, shr;
      j = 1 - k;
      req_valid[k] = 1'b1; req_write[k] = wr; req_addr[k] = a;
      if (with_snp) begin
         for (int q = 0; q < NC; q++) begin
            s_valid[q] = 1'b1; s_cmd[q] = sc; s_addr[q] = a;
         end
         #1;
         for (int q = 0; q < NC; q++) snoop_chk_update(q, sc, a, rq);
      end
      idx = a[IW-1:0];
      if (m_hit(k, a) && (!wr || mst[k][idx] >= ME)) begin
         if (wr) mst[k][idx] = MM;
      end else begin
         if (!m_hit(k, a) && mst[k][idx] == MM) begin
            ec[0] = B_WB; ea[0] = {mtg[k][idx], idx}; n = 1;
         end
         ec[n] = wr ? B_RDX : B_RD; ea[n] = a; n++;
      end
      while (!fin) begin
         @(negedge clk);
         cyc++;
         gnt = '0; s_valid = '0;
         if (done[k]) begin
            check(gi == n, rq, "bus transactions seen", gi, n);
            if (n == 0) check(cyc == 1, rq, "hit latency", cyc, 1);
            else        check(cyc == last_g + 1, rq, "done after last grant", cyc, last_g + 1);
            req_valid[k] = 1'b0;
            fin = 1'b1;
         end else if (bq_valid[k]) begin
            c = bq_cmd[k]; ad = bq_addr[k];
            check(gi < n && c == ec[gi] && ad == ea[gi], rq, "bus cmd/addr",
                  int'({c, ad}), (gi < n) ? int'({ec[gi], ea[gi]}) : -1);
            gnt[k] = 1'b1;
            s_valid[j] = 1'b1; s_cmd[j] = c; s_addr[j] = ad;
            shr = exp_shared(j, c, ad);
            #1;
            snoop_chk_update(j, c, ad, rq);
            if (c == B_WB) mst[k][ad[IW-1:0]] = MI;
            else begin
               mtg[k][ad[IW-1:0]] = ad[AW-1:IW];
               mst[k][ad[IW-1:0]] = (c == B_RDX) ? MM : (shr ? MS : ME);
            end
            gi++; last_g = cyc;
         end
         if (!fin && cyc > 20) begin
            check(1'b0, rq, "completion timeout", cyc, 20);
            req_valid[k] = 1'b0; fin = 1'b1;
         end
      end
      @(negedge clk);
      inv_chk();
   endtask

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      check(1'b0, "WDOG", "watchdog expired", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      int unsigned seed_dummy;
      logic [AW-1:0] ra;
      req_valid = '0; req_write = '0; gnt = '0; s_valid = '0;
      for (int q = 0; q < NC; q++) begin
         req_addr[q] = '0; s_cmd[q] = '0; s_addr[q] = '0;
         for (int i = 0; i < 4; i++) begin mst[q][i] = MI; mtg[q][i] = '0; end
      end
      seed_dummy = $urandom(32'd1234);
      repeat (3) @(negedge clk);
      check(done == '0, "R1", "cpu_done in reset", int'(done), 0);
      check(bq_valid == '0, "R1", "bus_req_valid in reset", int'(bq_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(bq_valid == '0 && done == '0, "R1", "idle after reset", int'({bq_valid, done}), 0);
      for (int i = 0; i < 4; i++) ext_snoop(B_RD, AW'(i), "R1");

      cpu_op(0, 1'b0, 8'h04, 1'b0, 2'd0, "R2");   // miss, nobody shares -> E
      cpu_op(0, 1'b0, 8'h04, 1'b0, 2'd0, "R5");   // read hit
      cpu_op(0, 1'b1, 8'h04, 1'b0, 2'd0, "R4");   // silent E->M
      cpu_op(0, 1'b1, 8'h04, 1'b0, 2'd0, "R4");   // write hit M
      cpu_op(1, 1'b0, 8'h04, 1'b0, 2'd0, "R7");   // peer M flushes, both S (R2 shared fill, R6)
      cpu_op(1, 1'b1, 8'h04, 1'b0, 2'd0, "R3");   // write to S -> RDX, peer invalidated (R8)
      cpu_op(0, 1'b0, 8'h04, 1'b0, 2'd0, "R7");   // peer M flushes on read
      cpu_op(1, 1'b1, 8'h08, 1'b0, 2'd0, "R10");  // S victim dropped silently (R3 write miss)
      cpu_op(1, 1'b0, 8'h04, 1'b0, 2'd0, "R10");  // M victim written back first
      ext_snoop(B_RDX, 8'h04, "R8");
      ext_snoop(B_WB, 8'h04, "R6");
      cpu_op(0, 1'b0, 8'h05, 1'b0, 2'd0, "R2");   // fill E
      cpu_op(0, 1'b1, 8'h05, 1'b1, B_RDX, "R9");  // snoop first -> write needs RDX
      ext_snoop(B_RD, 8'h05, "R7");               // M -> S with flush
      ext_snoop(B_RD, 8'h05, "R6");               // S stays S, shared
      cpu_op(0, 1'b1, 8'h05, 1'b0, 2'd0, "R3");
      cpu_op(0, 1'b1, 8'h09, 1'b0, 2'd0, "R10");

      for (int t = 0; t < 600; t++) begin
         ra = {AW'($urandom_range(0, 2)) << IW} | AW'($urandom_range(0, 3));
         if ($urandom_range(0, 6) == 0)
            ext_snoop(2'($urandom_range(1, 3)), ra, "R8");
         else
            cpu_op(int'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), ra, 1'b0, 2'd0, "R11");
      end

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule